// File: doc/BRIEF.md
# Effective Address Calculation Unit

This unit resolves the operand reference of one instruction. It takes a 4-bit mode code, a register selector and an address field. Depending on the mode, it returns one of two things. The first is an operand value: a constant, the field itself, or a register's content. The second is an effective address, formed from the field, a register, the program counter, an index value or a base value. The unit holds a small file of general registers. Autoincrement and autodecrement modes update those registers as a side effect. A load port lets the surrounding pipeline write the registers.

One mode needs a word from memory: the address field points at the effective address. For that mode the unit raises a memory request and holds it until the memory answers with a valid strobe. It then completes with the word it read back. Every other mode completes one clock after the start strobe. A `done` pulse marks a valid result. While the unit waits for memory, a new start is not accepted.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done`, `mem_req`, `busy` and `illegal` are low, and every general register reads back as zero.
- R2: A start with mode 0 (implied) gives result 0 with `is_addr`=0. Mode 1 (immediate) gives the address field with `is_addr`=0. Mode 6 (direct) gives the address field with `is_addr`=1. In all three, `done` is high in the cycle after start and no memory request is made.
- R3: Mode 2 (register) returns the selected register's content with `is_addr`=0. Mode 3 (register indirect) returns it with `is_addr`=1. Neither changes the register.
- R4: Mode 4 (autoincrement) returns the selected register's old content with `is_addr`=1. Afterwards the register holds the old value plus one, modulo 2^AW.
- R5: Mode 5 (autodecrement) first lowers the selected register by one, modulo 2^AW. It returns the lowered value with `is_addr`=1.
- R6: Mode 8 returns `pc_next` plus the field. Mode 9 returns `index_val` plus the field. Mode 10 returns `base_val` plus the field. Each sum wraps modulo 2^AW, and `is_addr` is 1.
- R7: Mode 7 (indirect) raises `mem_req` in the cycle after start, with `mem_addr` equal to the field. Both are held unchanged until `mem_valid` is sampled high. In the next cycle `done` is high, `result` equals the `mem_rdata` sampled with `mem_valid`, `is_addr` is 1 and `mem_req` is low.
- R8: Mode codes 11 to 15 complete in the cycle after start with `illegal`=1 and result 0. They make no memory request and change no register. A legal completion has `illegal`=0.
- R9: A start while `busy` is high is ignored. It produces no `done` and has no register side effect.
- R10: A load-port write and an autoincrement or autodecrement update can fall on the same register in the same cycle. In that case the load value is stored. The returned result still uses the register's value from before that cycle. When the two hit different registers, both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving one operand reference |
| mode | input | 4 | Addressing mode code |
| reg_sel | input | RK | General register selector |
| addr_field | input | AW | Address field of the instruction |
| pc_next | input | AW | Program counter already advanced past the instruction |
| index_val | input | AW | Index register value |
| base_val | input | AW | Base register value |
| ld_en | input | 1 | Write strobe of the register load port |
| ld_idx | input | RK | Register written by the load port |
| ld_val | input | AW | Value written by the load port |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | AW | Memory read data |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | AW | Operand value or effective address |
| is_addr | output | 1 | 1 when result is an effective address |
| illegal | output | 1 | Mode code was not recognised |
| busy | output | 1 | Waiting for a memory answer |

## Verification
Two writes can reach the register file in the same cycle: the load port, and the post-increment or pre-decrement side effect of a start. The bench drives both in one cycle, first aimed at the same register and then at two different registers. It checks the returned result against the value before that cycle. It then reads each register back through register mode and compares with a model in which the load wins. Boundary values 0x00 and 0xFF are loaded beforehand to expose wrap errors in the update path.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        M_IMPLIED  = 4'd0,
        M_IMMED    = 4'd1,
        M_REG      = 4'd2,
        M_REG_IND  = 4'd3,
        M_AUTO_INC = 4'd4,
        M_AUTO_DEC = 4'd5,
        M_DIRECT   = 4'd6,
        M_INDIRECT = 4'd7,
        M_REL      = 4'd8,
        M_INDEXED  = 4'd9,
        M_BASED    = 4'd10
    } mode_e;

    // Operand source feeding the shared adder
    typedef enum logic [2:0] {
        SRC_ZERO,
        SRC_FIELD,
        SRC_REG,
        SRC_REG_M1,
        SRC_PC,
        SRC_IDX,
        SRC_BASE
    } src_e;

    typedef struct packed {
        logic legal;
        logic is_addr;
        logic need_mem;
        logic inc;
        logic dec;
        src_e src;
    } dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } st_e;

endpackage

// File: rtl/ea_decode.sv
module ea_decode
    import ea_pkg::*;
(
    input  logic [3:0] mode,
    output dec_t       dec
);

    always_comb begin
        dec = '{legal: 1'b1, is_addr: 1'b1, need_mem: 1'b0,
                inc: 1'b0, dec: 1'b0, src: SRC_ZERO};
        case (mode)
            M_IMPLIED:  begin dec.is_addr = 1'b0; dec.src = SRC_ZERO;  end
            M_IMMED:    begin dec.is_addr = 1'b0; dec.src = SRC_FIELD; end
            M_REG:      begin dec.is_addr = 1'b0; dec.src = SRC_REG;   end
            M_REG_IND:  dec.src = SRC_REG;
            M_AUTO_INC: begin dec.src = SRC_REG;    dec.inc = 1'b1; end
            M_AUTO_DEC: begin dec.src = SRC_REG_M1; dec.dec = 1'b1; end
            M_DIRECT:   dec.src = SRC_FIELD;
            M_INDIRECT: dec.need_mem = 1'b1;
            M_REL:      dec.src = SRC_PC;
            M_INDEXED:  dec.src = SRC_IDX;
            M_BASED:    dec.src = SRC_BASE;
            default: begin
                dec.legal   = 1'b0;
                dec.is_addr = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    output logic [AW-1:0] s
);

    // Wraps modulo 2^AW: carry out is dropped
    assign s = a + b;

endmodule

// File: rtl/ea_regfile.sv
module ea_regfile #(
    parameter int AW = 8,
    parameter int RK = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RK-1:0] rd_idx,
    output logic [AW-1:0] rd_val,
    input  logic          upd_en,
    input  logic [RK-1:0] upd_idx,
    input  logic [AW-1:0] upd_val,
    input  logic          ld_en,
    input  logic [RK-1:0] ld_idx,
    input  logic [AW-1:0] ld_val
);

    localparam int NREG = 1 << RK;

    logic [AW-1:0] regs_q [NREG];
    logic [AW-1:0] regs_d [NREG];

    assign rd_val = regs_q[rd_idx];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (ld_en && ld_idx == RK'(i)) begin
                regs_d[i] = ld_val;
            end else if (upd_en && upd_idx == RK'(i)) begin
                regs_d[i] = upd_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW = 8,
    parameter int RK = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [RK-1:0] reg_sel,
    input  logic [AW-1:0] addr_field,
    input  logic [AW-1:0] pc_next,
    input  logic [AW-1:0] index_val,
    input  logic [AW-1:0] base_val,
    input  logic          ld_en,
    input  logic [RK-1:0] ld_idx,
    input  logic [AW-1:0] ld_val,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic [AW-1:0] result,
    output logic          is_addr,
    output logic          illegal,
    output logic          busy
);

    localparam logic [AW-1:0] ONE     = AW'(1);
    localparam logic [AW-1:0] MINUS_1 = '1;

    typedef struct packed {
        st_e           st;
        logic          done;
        logic [AW-1:0] result;
        logic          is_addr;
        logic          illegal;
        logic          mem_req;
        logic [AW-1:0] mem_addr;
    } state_t;

    state_t state_d, state_q;

    dec_t          dec;
    logic [AW-1:0] rf_val;
    logic [AW-1:0] sum_a, sum_b, sum_s, inc_s;
    logic          accept;
    logic          upd_en;
    logic [AW-1:0] upd_val;

    ea_decode u_dec (
        .mode (mode),
        .dec  (dec)
    );

    ea_regfile #(.AW(AW), .RK(RK)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (reg_sel),
        .rd_val  (rf_val),
        .upd_en  (upd_en),
        .upd_idx (reg_sel),
        .upd_val (upd_val),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_val  (ld_val)
    );

    // One adder serves field, register, decrement and base-plus-offset sums
    ea_sum #(.AW(AW)) u_sum (
        .a (sum_a),
        .b (sum_b),
        .s (sum_s)
    );

    ea_sum #(.AW(AW)) u_inc (
        .a (rf_val),
        .b (ONE),
        .s (inc_s)
    );

    always_comb begin
        sum_a = '0;
        sum_b = '0;
        case (dec.src)
            SRC_FIELD:  sum_b = addr_field;
            SRC_REG:    sum_a = rf_val;
            SRC_REG_M1: begin sum_a = rf_val;    sum_b = MINUS_1;    end
            SRC_PC:     begin sum_a = pc_next;   sum_b = addr_field; end
            SRC_IDX:    begin sum_a = index_val; sum_b = addr_field; end
            SRC_BASE:   begin sum_a = base_val;  sum_b = addr_field; end
            default:    ;
        endcase
    end

    assign accept  = start && (state_q.st == ST_IDLE);
    assign upd_en  = accept && (dec.inc || dec.dec);
    assign upd_val = dec.dec ? sum_s : inc_s;

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        case (state_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (!dec.legal) begin
                        state_d.done    = 1'b1;
                        state_d.illegal = 1'b1;
                        state_d.result  = '0;
                        state_d.is_addr = 1'b0;
                    end else if (dec.need_mem) begin
                        state_d.st       = ST_WAIT;
                        state_d.mem_req  = 1'b1;
                        state_d.mem_addr = addr_field;
                        state_d.illegal  = 1'b0;
                    end else begin
                        state_d.done    = 1'b1;
                        state_d.illegal = 1'b0;
                        state_d.result  = sum_s;
                        state_d.is_addr = dec.is_addr;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_valid) begin
                    state_d.st      = ST_IDLE;
                    state_d.mem_req = 1'b0;
                    state_d.done    = 1'b1;
                    state_d.result  = mem_rdata;
                    state_d.is_addr = 1'b1;
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{st: ST_IDLE, done: 1'b0, result: '0, is_addr: 1'b0,
                         illegal: 1'b0, mem_req: 1'b0, mem_addr: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign done     = state_q.done;
    assign result   = state_q.result;
    assign is_addr  = state_q.is_addr;
    assign illegal  = state_q.illegal;
    assign mem_req  = state_q.mem_req;
    assign mem_addr = state_q.mem_addr;
    assign busy     = (state_q.st == ST_WAIT);

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
    parameter int AW = 8,
    parameter int RK = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [3:0]    mode,
    input logic [RK-1:0] reg_sel,
    input logic [AW-1:0] addr_field,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_valid,
    input logic [AW-1:0] mem_rdata,
    input logic          done,
    input logic [AW-1:0] result,
    input logic          is_addr,
    input logic          illegal,
    input logic          busy
);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

    assert_ind_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_valid |=> done && is_addr && !mem_req && result == $past(mem_rdata));

    assert_done_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && mode == 4'd6 |=> done && is_addr && !mem_req && result == $past(addr_field));

    assert_bad_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && mode > 4'd10 |=> done && illegal && !mem_req && result == '0);

    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_valid |=> !done && busy);

    // reg_sel is part of the observed interface but needs no property of its own
    logic unused_sel;
    assign unused_sel = ^reg_sel;

endmodule

bind ea_unit ea_unit_chk #(.AW(AW), .RK(RK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .reg_sel    (reg_sel),
    .addr_field (addr_field),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .mem_rdata  (mem_rdata),
    .done       (done),
    .result     (result),
    .is_addr    (is_addr),
    .illegal    (illegal),
    .busy       (busy)
);

// File: tb/ea_unit_bench.sv
module ea_unit_bench;

    localparam int AW = 8;
    localparam int RK = 2;
    localparam int NREG = 1 << RK;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    mode = '0;
    logic [RK-1:0] reg_sel = '0;
    logic [AW-1:0] addr_field = '0;
    logic [AW-1:0] pc_next = '0, index_val = '0, base_val = '0;
    logic          ld_en = 1'b0;
    logic [RK-1:0] ld_idx = '0;
    logic [AW-1:0] ld_val = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_valid = 1'b0;
    logic [AW-1:0] mem_rdata = '0;
    logic          done, is_addr, illegal, busy;
    logic [AW-1:0] result;

    logic [AW-1:0] mdl [NREG];
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    ea_unit #(.AW(AW), .RK(RK)) u_ea_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_sel(reg_sel),
        .addr_field(addr_field), .pc_next(pc_next), .index_val(index_val),
        .base_val(base_val), .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .done(done), .result(result), .is_addr(is_addr),
        .illegal(illegal), .busy(busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 200000) begin
            errors = errors + 1;
            $display("FAIL R7 watchdog expired actual=%0d expected=<200000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [RK-1:0] idx, input logic [AW-1:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_val = val;
        @(negedge clk);
        ld_en = 1'b0;
        mdl[idx] = val;
    endtask

    // Start one reference; returns at the negedge after the capturing edge
    task automatic run(input logic [3:0] md, input logic [RK-1:0] sel, input logic [AW-1:0] fld);
        @(negedge clk);
        start = 1'b1; mode = md; reg_sel = sel; addr_field = fld;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic read_reg(input logic [RK-1:0] sel, input string req);
        run(4'd2, sel, '0);
        chk(req, {31'd0, done}, 32'd1);
        chk(req, {24'd0, result}, {24'd0, mdl[sel]});
    endtask

    initial begin
        logic [AW-1:0] er;
        logic          ea;
        logic          eill;

        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 illegal", {31'd0, illegal}, 32'd0);
        for (int r = 0; r < NREG; r++) read_reg(RK'(r), "R1 reg zero");

        // Sweep of every non-memory mode, all registers, fields in steps of 3
        for (int md = 0; md < 16; md++) begin
            if (md == 7) continue;
            for (int s = 0; s < NREG; s++) begin
                for (int f = 0; f < 256; f += 3) begin
                    pc_next   = AW'(f * 3 + 17);
                    index_val = ~AW'(f);
                    base_val  = AW'(f) ^ 8'h5C;
                    if (md >= 2 && md <= 5) load(RK'(s), AW'(f * 7 + s));
                    er = '0; ea = 1'b1; eill = 1'b0;
                    case (md)
                        0: ea = 1'b0;
                        1: begin er = AW'(f); ea = 1'b0; end
                        2: begin er = mdl[s]; ea = 1'b0; end
                        3: er = mdl[s];
                        4: begin er = mdl[s]; mdl[s] = mdl[s] + 1'b1; end
                        5: begin mdl[s] = mdl[s] - 1'b1; er = mdl[s]; end
                        6: er = AW'(f);
                        8: er = pc_next + AW'(f);
                        9: er = index_val + AW'(f);
                        10: er = base_val + AW'(f);
                        default: begin ea = 1'b0; eill = 1'b1; end
                    endcase
                    run(4'(md), RK'(s), AW'(f));
                    if (md <= 1 || md == 6) begin
                        chk("R2 done", {31'd0, done}, 32'd1);
                        chk("R2 result", {24'd0, result}, {24'd0, er});
                        chk("R2 is_addr", {31'd0, is_addr}, {31'd0, ea});
                        chk("R2 no mem_req", {31'd0, mem_req}, 32'd0);
                    end else if (md <= 3) begin
                        chk("R3 result", {24'd0, result}, {24'd0, er});
                        chk("R3 is_addr", {31'd0, is_addr}, {31'd0, ea});
                    end else if (md == 4) begin
                        chk("R4 result", {24'd0, result}, {24'd0, er});
                        chk("R4 is_addr", {31'd0, is_addr}, 32'd1);
                    end else if (md == 5) begin
                        chk("R5 result", {24'd0, result}, {24'd0, er});
                        chk("R5 is_addr", {31'd0, is_addr}, 32'd1);
                    end else if (md <= 10) begin
                        chk("R6 done", {31'd0, done}, 32'd1);
                        chk("R6 result", {24'd0, result}, {24'd0, er});
                        chk("R6 is_addr", {31'd0, is_addr}, 32'd1);
                    end else begin
                        chk("R8 done", {31'd0, done}, 32'd1);
                        chk("R8 result", {24'd0, result}, 32'd0);
                        chk("R8 no mem_req", {31'd0, mem_req}, 32'd0);
                    end
                    chk("R8 illegal flag", {31'd0, illegal}, {31'd0, eill});
                    if (md == 3) read_reg(RK'(s), "R3 reg unchanged");
                    if (md == 4) read_reg(RK'(s), "R4 reg incremented");
                    if (md == 5) read_reg(RK'(s), "R5 reg decremented");
                    if (md > 10) read_reg(RK'(s), "R8 reg unchanged");
                end
            end
        end

        // R4 / R5 wrap at the boundaries
        load(2'd1, 8'hFF);
        run(4'd4, 2'd1, 8'h00);
        chk("R4 wrap result", {24'd0, result}, 32'hFF);
        mdl[1] = 8'h00;
        read_reg(2'd1, "R4 wrap reg");
        load(2'd1, 8'h00);
        run(4'd5, 2'd1, 8'h00);
        chk("R5 wrap result", {24'd0, result}, 32'hFF);
        mdl[1] = 8'hFF;
        read_reg(2'd1, "R5 wrap reg");

        // R7 / R9: indirect with 0..3 cycle memory delay, ignored starts in between
        load(2'd1, 8'h33);
        for (int f = 0; f < 256; f += 17) begin
            run(4'd7, 2'd0, AW'(f));
            chk("R7 mem_req", {31'd0, mem_req}, 32'd1);
            chk("R7 mem_addr", {24'd0, mem_addr}, f);
            chk("R7 busy", {31'd0, busy}, 32'd1);
            chk("R7 no early done", {31'd0, done}, 32'd0);
            for (int d = 0; d < f % 4; d++) begin
                start = 1'b1; mode = 4'd4; reg_sel = 2'd1; addr_field = 8'hAA;
                @(negedge clk);
                start = 1'b0;
                chk("R9 no done while busy", {31'd0, done}, 32'd0);
                chk("R7 mem_req held", {31'd0, mem_req}, 32'd1);
                chk("R7 mem_addr held", {24'd0, mem_addr}, f);
            end
            mem_valid = 1'b1; mem_rdata = AW'(f) ^ 8'h96;
            @(negedge clk);
            mem_valid = 1'b0;
            chk("R7 done", {31'd0, done}, 32'd1);
            chk("R7 result", {24'd0, result}, {24'd0, AW'(f) ^ 8'h96});
            chk("R7 is_addr", {31'd0, is_addr}, 32'd1);
            chk("R7 req dropped", {31'd0, mem_req}, 32'd0);
            chk("R7 busy dropped", {31'd0, busy}, 32'd0);
            @(negedge clk);
            chk("R9 single done", {31'd0, done}, 32'd0);
            read_reg(2'd1, "R9 no side effect");
        end

        // R10: load and autoincrement on the same register
        load(2'd2, 8'h40);
        @(negedge clk);
        start = 1'b1; mode = 4'd4; reg_sel = 2'd2;
        ld_en = 1'b1; ld_idx = 2'd2; ld_val = 8'h9A;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        chk("R10 same reg result", {24'd0, result}, 32'h40);
        mdl[2] = 8'h9A;
        read_reg(2'd2, "R10 load wins");

        // R10: load and autodecrement on different registers
        load(2'd3, 8'h10);
        @(negedge clk);
        start = 1'b1; mode = 4'd5; reg_sel = 2'd3;
        ld_en = 1'b1; ld_idx = 2'd0; ld_val = 8'h77;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        chk("R10 diff reg result", {24'd0, result}, 32'h0F);
        mdl[3] = 8'h0F;
        mdl[0] = 8'h77;
        read_reg(2'd3, "R10 decrement kept");
        read_reg(2'd0, "R10 load kept");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule